// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block turns a binary sample word into the switch controls of a segmented current-steering converter. The upper field of the word selects how many equal-weight unary current cells conduct. The lower field drives a small set of binary-weighted cells directly. The unary cells are not enabled in index order. They follow a fixed scattered sequence across the cell array, so that linear and gradient mismatch in the array averages out as the code grows rather than building up.

A sample enters on every clock. All switch controls leave from one register bank, so every current switch toggles on the same edge. The unary enables pass through a thermometer decoder and a position-to-cell permutation. The binary bits are held back by a matching register so that both segments stay aligned. The block sustains one new word per cycle at the full sample rate, up to 80 MS/s.

Top module: `dacseg_top`

## Requirements
- R1: The 12-bit `code` is split into M = `code[11:4]`, which controls the 255 unary cells, and `code[3:0]`, which controls the binary cells. No bit of one field affects the other field's outputs.
- R2: For a field value M, exactly M of the 255 `unary_sw` bits are high.
- R3: Sequence position p (0 to 254) belongs to physical cell (127 + 77·p) mod 255. Cell c is high exactly when its sequence position is below M. M = 0 gives all cells low and M = 255 gives all cells high.
- R4: Unary switching is monotonic. Every cell that is high for a value M is also high for every larger value.
- R5: `bin_sw[i]` equals `code[i]` for i = 0 to 3, and bit i carries weight 2^i.
- R6: Every output is registered. A word applied before clock edge k appears on both `unary_sw` and `bin_sw` after edge k+1, and both segments change at the same edge.
- R7: Reset is synchronous and active high. After any edge with `rst` high, every output is 0, whatever `code` is.
- R8: Every nonzero M turns on cell 127, the first cell in the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | 12 | Sample word; upper 8 bits unary, lower 4 bits binary |
| unary_sw | output | 255 | Unary cell enables, indexed by physical cell |
| bin_sw | output | 4 | Binary-weighted cell enables, bit i of weight 2^i |

## Verification
A corrupted permutation or thermometer stage shows up two cycles after the offending word, as the wrong number of high unary bits or as the right count on the wrong cells. A monotonic ramp of M exposes an out-of-place cell on the first step whose newly added cell differs from the stated sequence. A mismatch in the delay of the binary path shows as `bin_sw` holding a neighbouring sample's low bits on any cycle where consecutive words differ. A stuck pipeline register shows as outputs that fail to clear one edge after reset.

// File: rtl/dacseg_pkg.sv
package dacseg_pkg;

   // Greatest common divisor, used to prove the stride visits every cell.
   function automatic int gcd_of(input int a, input int b);
      int x;
      int y;
      int t;
      x = a;
      y = b;
      while (y != 0) begin
         t = x % y;
         x = y;
         y = t;
      end
      return x;
   endfunction

   // Physical cell that owns sequence position pos.
   function automatic int seq_to_cell(input int pos, input int n_cells,
                                      input int stride, input int start);
      return (start + pos * stride) % n_cells;
   endfunction

endpackage

// File: rtl/dacseg_pipe_reg.sv
module dacseg_pipe_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end
endmodule

// File: rtl/dacseg_thermo.sv
module dacseg_thermo #(
   parameter int MSB_W = 8
) (
   input  logic [MSB_W-1:0]         level,
   output logic [(1<<MSB_W)-2:0]    seq_en
);
   localparam int N_CELLS = (1 << MSB_W) - 1;

   for (genvar p = 0; p < N_CELLS; p++) begin : g_pos
      assign seq_en[p] = (level > MSB_W'(p));
   end
endmodule

// File: rtl/dacseg_scatter.sv
module dacseg_scatter #(
   parameter int N_CELLS = 255,
   parameter int STRIDE  = 77,
   parameter int START   = 127
) (
   input  logic [N_CELLS-1:0] seq_en,
   output logic [N_CELLS-1:0] cell_en
);
   for (genvar p = 0; p < N_CELLS; p++) begin : g_route
      assign cell_en[dacseg_pkg::seq_to_cell(p, N_CELLS, STRIDE, START)] = seq_en[p];
   end
endmodule

// File: rtl/dacseg_top.sv
module dacseg_top #(
   parameter int CODE_W     = 12,
   parameter int LSB_W      = 4,
   parameter int STRIDE     = 77,
   parameter int START      = 127,
   parameter bit SCATTER_EN = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic [CODE_W-1:0]                 code,
   output logic [(1<<(CODE_W-LSB_W))-2:0]    unary_sw,
   output logic [LSB_W-1:0]                  bin_sw
);
   localparam int MSB_W   = CODE_W - LSB_W;
   localparam int N_CELLS = (1 << MSB_W) - 1;
   localparam int OUT_W   = N_CELLS + LSB_W;

   if (LSB_W < 1 || MSB_W < 1) begin : g_bad_split
      $error("dacseg_top: both segments need at least one bit");
   end
   if (MSB_W > 10) begin : g_bad_size
      $error("dacseg_top: unary segment too large");
   end
   if (SCATTER_EN && dacseg_pkg::gcd_of(STRIDE, N_CELLS) != 1) begin : g_bad_stride
      $error("dacseg_top: stride must be coprime with the cell count");
   end
   if (START < 0 || START >= N_CELLS) begin : g_bad_start
      $error("dacseg_top: start cell outside the array");
   end

   logic [CODE_W-1:0]  code_q;
   logic [N_CELLS-1:0] seq_en;
   logic [N_CELLS-1:0] cell_en;

   // Stage 1: capture the sample word
   dacseg_pipe_reg #(.W(CODE_W)) u_in_reg (
      .clk (clk),
      .rst (rst),
      .d   (code),
      .q   (code_q)
   );

   dacseg_thermo #(.MSB_W(MSB_W)) u_thermo (
      .level  (code_q[CODE_W-1:LSB_W]),
      .seq_en (seq_en)
   );

   if (SCATTER_EN) begin : g_scatter
      dacseg_scatter #(
         .N_CELLS (N_CELLS),
         .STRIDE  (STRIDE),
         .START   (START)
      ) u_scatter (
         .seq_en  (seq_en),
         .cell_en (cell_en)
      );
   end else begin : g_linear
      assign cell_en = seq_en;
   end

   // Stage 2: one bank drives every switch on the same edge
   dacseg_pipe_reg #(.W(OUT_W)) u_out_reg (
      .clk (clk),
      .rst (rst),
      .d   ({cell_en, code_q[LSB_W-1:0]}),
      .q   ({unary_sw, bin_sw})
   );
endmodule

// File: rtl/dacseg_chk.sv
module dacseg_chk #(
   parameter int CODE_W     = 12,
   parameter int LSB_W      = 4,
   parameter int START      = 127,
   parameter bit SCATTER_EN = 1'b1
) (
   input logic                              clk,
   input logic                              rst,
   input logic [CODE_W-1:0]                 code,
   input logic [(1<<(CODE_W-LSB_W))-2:0]    unary_sw,
   input logic [LSB_W-1:0]                  bin_sw
);
   localparam int FIRST = SCATTER_EN ? START : 0;

   logic [1:0] age;
   logic       rst_d;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst)            age <= 2'd0;
      else if (age != 3)  age <= age + 2'd1;
   end

   // R2 with R6: count of live cells follows the field two edges back
   assert_cell_count_R2: assert property (@(posedge clk) disable iff (rst)
      (age >= 2) |-> ($countones(unary_sw) == int'($past(code[CODE_W-1:LSB_W], 2))));

   // R5 with R6: binary controls are the low field two edges back
   assert_binary_path_R5: assert property (@(posedge clk) disable iff (rst)
      (age >= 2) |-> (bin_sw == $past(code[LSB_W-1:0], 2)));

   // R4: a larger cell count keeps every cell that was already on
   assert_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
      ((age >= 2) && ($countones(unary_sw) >= $countones($past(unary_sw))))
         |-> ((unary_sw & $past(unary_sw)) == $past(unary_sw)));

   // R8: any live cell implies the first cell of the sequence
   assert_first_cell_R8: assert property (@(posedge clk) disable iff (rst)
      (|unary_sw) |-> unary_sw[FIRST]);

   // R7: one edge of reset clears every switch
   always @(posedge clk) begin
      if (rst_d) begin
         assert_reset_clear_R7: assert (unary_sw == '0 && bin_sw == '0);
      end
   end
endmodule

bind dacseg_top dacseg_chk #(
   .CODE_W     (CODE_W),
   .LSB_W      (LSB_W),
   .START      (START),
   .SCATTER_EN (SCATTER_EN)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .code     (code),
   .unary_sw (unary_sw),
   .bin_sw   (bin_sw)
);

// File: tb/tb_dacseg_top.sv
module tb_dacseg_top;
   localparam int NC     = 255;
   localparam int STRIDE = 77;
   localparam int START  = 127;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [11:0]   code = '0;
   logic [NC-1:0] unary_sw;
   logic [3:0]    bin_sw;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   dacseg_top dut (
      .clk      (clk),
      .rst      (rst),
      .code     (code),
      .unary_sw (unary_sw),
      .bin_sw   (bin_sw)
   );

   // R6 reference: two stages, both cleared by reset
   logic [11:0] h0 = '0;
   logic [11:0] h1 = '0;
   bit          rst_edge = 0;
   bit          started  = 0;

   always @(posedge clk) begin
      started  <= 1;
      rst_edge <= rst;
      if (rst) begin
         h0 <= '0;
         h1 <= '0;
      end else begin
         h0 <= code;
         h1 <= h0;
      end
   end

   function automatic logic [NC-1:0] ref_unary(input int m);
      logic [NC-1:0] v;
      v = '0;
      for (int p = 0; p < m; p++) v[(START + p * STRIDE) % NC] = 1'b1;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input logic [NC-1:0] act,
                        input logic [NC-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   logic [NC-1:0] prev_u = '0;
   int            prev_m = 0;

   always @(negedge clk) begin
      if (started && !done) begin
         logic [NC-1:0] eu;
         int m;
         m  = int'(h1[11:4]);
         eu = ref_unary(m);
         // R1 R2 R3: cell pattern from the upper field only
         check(unary_sw === eu, "R1/R2/R3 unary pattern", unary_sw, eu);
         // R5: binary segment
         check(bin_sw === h1[3:0], "R5 binary bits", NC'(bin_sw), NC'(h1[3:0]));
         if (rst_edge)
            check(unary_sw === '0 && bin_sw === '0, "R7 reset clear",
                  NC'(unary_sw), '0);
         if (m >= prev_m)
            check((unary_sw & prev_u) === prev_u, "R4 monotonic", unary_sw, prev_u);
         if (m > 0)
            check(unary_sw[START] === 1'b1, "R8 first cell", NC'(unary_sw[START]), NC'(1));
         prev_u = unary_sw;
         prev_m = m;
      end
   end

   task automatic drive(input logic [11:0] v);
      @(negedge clk);
      #1 code = v;
   endtask

   task automatic report();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      code = 12'hFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1 rst = 1'b0;
      // ramp up through every unary level
      for (int m = 0; m < 256; m++) drive({m[7:0], m[3:0] ^ 4'h5});
      // ramp down
      for (int m = 255; m >= 0; m--) drive({m[7:0], m[3:0]});
      // boundaries
      drive(12'h000); drive(12'hFFF); drive(12'h000); drive(12'h010);
      drive(12'h00F); drive(12'hFF0); drive(12'hFFF); drive(12'h0F0);
      // mid-run reset with full-scale input (R7)
      drive(12'hFFF);
      @(negedge clk); #1 rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk); #1 rst = 1'b0;
      // random words
      for (int i = 0; i < 400; i++) drive(12'($urandom));
      repeat (4) @(posedge clk);
      @(negedge clk);
      report();
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end
endmodule